// File: doc/BRIEF.md
# Cartridge Bank Address Translator

This block sits between a console's CPU and picture-processor address buses and the cartridge memories. From four 5-bit control registers and a handful of board straps it works out which physical location of program ROM, work RAM, character memory or the console's internal nametable RAM each bus address lands on, and which of those devices is enabled. Loading the control registers is done elsewhere; this block only reads their current values.

Program space at 0x8000–0xFFFF is split into two 16 KB windows that either move together as one 32 KB bank or move singly with the other window pinned to the first or last bank. Character space at 0x0000–0x1FFF is switched either as one 8 KB bank or as two independent 4 KB banks. The nametable A10 line is driven for single-screen, vertical or horizontal mirroring. Boards with a 512 KB program ROM or with more than 8 KB of work RAM borrow spare high bits of a character register as extra bank bits; a board strap can also lock program space to a plain, unbanked 32 KB map.

All outputs are registered: the translation for the inputs present at one rising clock edge appears on the outputs after that edge and stays until the next. Reset is synchronous and active high.

Top module: `cart_bank_xlat`

## Requirements
- R1: With `ppu_addr[13]` = 1, `nt_ce` is 1, `chr_ce` is 0, and `nt_a10` follows `ctl_mode[1:0]`: 0 gives constant 0, 1 gives constant 1, 2 (vertical) gives `ppu_addr[10]`, 3 (horizontal) gives `ppu_addr[11]`.
- R2: With `ctl_mode[3]` = 0 (32 KB program mode), the 16 KB bank is `{ctl_prg[3:1], cpu_addr[14]}`, i.e. the even bank `ctl_prg & 0x0E` for 0x8000–0xBFFF and that bank plus one for 0xC000–0xFFFF.
- R3: With `ctl_mode[3]` = 1 (16 KB mode): if `ctl_mode[2]` = 1, 0x8000–0xBFFF uses bank `ctl_prg[3:0]` and 0xC000–0xFFFF uses bank 15; if `ctl_mode[2]` = 0, 0x8000–0xBFFF uses bank 0 and 0xC000–0xFFFF uses bank `ctl_prg[3:0]`.
- R4: For `ppu_addr[13]` = 0, `chr_ce` is 1 and `nt_ce` 0. With `ctl_mode[4]` = 1 (4 KB mode) the 4 KB bank is `ctl_chr_lo` for 0x0000–0x0FFF and `ctl_chr_hi` for 0x1000–0x1FFF; with `ctl_mode[4]` = 0 it is `{ctl_chr_lo[4:1], ppu_addr[12]}`.
- R5: `ram_ce` is 1 only for `cpu_addr` 0x6000–0x7FFF, and there only when `ctl_prg[4]` = 0 or `cfg_ram_force` = 1. `prg_ce` equals `cpu_addr[15]`.
- R6: The borrowed register is `ctl_chr_hi` when `chr_hi_last` = 1 and `ctl_mode[4]` = 1, otherwise `ctl_chr_lo`. With `cfg_prg_512k` = 1 its bit 4 becomes program bank bit 4 in every mode; with `cfg_prg_512k` = 0 program bank bit 4 is 0.
- R7: RAM bank and `ram_batt` follow `cfg_ram_size`: 3 (32 KB) bank = borrowed bits 3:2; 1 (8 KB battery + 8 KB work) bank = borrowed bit 3 and `ram_batt` = NOT that bit; 2 (16 KB single type) bank = borrowed bit 2; 0 (8 KB) bank 0. Outside size 1, `ram_batt` equals `cfg_battery`.
- R8: With `cfg_fixed32` = 1 the program bank is `cpu_addr[14]` (banks 0 and 1) whatever the registers and `cfg_prg_512k`.
- R9: `prg_addr` = bank × 16 KB + `cpu_addr[13:0]`; `chr_addr` = 4 KB bank × 4 KB + `ppu_addr[11:0]`; `ram_addr` = bank × 8 KB + `cpu_addr[12:0]`.
- R10: Outputs change one clock edge after the inputs; while `rst` is 1 every output is cleared to 0 at the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_mode | input | 5 | Mode register: mirroring, program slot, program size, character size |
| ctl_chr_lo | input | 5 | Character register for the lower 4 KB (also borrowed high bits) |
| ctl_chr_hi | input | 5 | Character register for the upper 4 KB (also borrowed high bits) |
| ctl_prg | input | 5 | Program bank register; bit 4 disables work RAM |
| chr_hi_last | input | 1 | 1 when the upper character register was the last one written |
| cfg_prg_512k | input | 1 | Board has a 512 KB program ROM |
| cfg_fixed32 | input | 1 | Board locks program space to an unbanked 32 KB map |
| cfg_ram_force | input | 1 | Work RAM stays enabled regardless of the disable bit |
| cfg_battery | input | 1 | Work RAM is battery backed |
| cfg_ram_size | input | 2 | RAM layout: 0 8 KB, 1 split 8+8 KB, 2 16 KB, 3 32 KB |
| cpu_addr | input | 16 | CPU address |
| ppu_addr | input | 14 | Picture-processor address |
| prg_ce | output | 1 | Program ROM enable |
| prg_addr | output | 19 | Physical program ROM address |
| ram_ce | output | 1 | Work RAM enable |
| ram_batt | output | 1 | Access goes to battery-backed RAM |
| ram_addr | output | 15 | Physical work RAM address |
| chr_ce | output | 1 | Character memory enable |
| chr_addr | output | 17 | Physical character memory address |
| nt_ce | output | 1 | Internal nametable RAM enable |
| nt_a10 | output | 1 | A10 line of the internal nametable RAM |

## Verification
The checker watches, on every cycle, the relations that hold for any register value: single-screen A holding the nametable line low, the disable bit switching work RAM off, the offset bits of program and 8 KB character addresses passing through unchanged, the locked 32 KB map, bank bit 4 staying clear on small boards, and the enables never overlapping. Which bank number each mode picks, the choice of borrowed register, the RAM bank and battery selection, and the reset and latency behaviour depend on particular register contents, so the directed scenarios show them with exact expected addresses.

// File: rtl/cart_bank_xlat_pkg.sv
package cart_bank_xlat_pkg;

    localparam int REG_W      = 5;
    localparam int CPU_AW     = 16;
    localparam int PPU_AW     = 14;
    localparam int PRG_BANK_W = 5;
    localparam int PRG_OFS_W  = 14;
    localparam int PRG_AW     = PRG_BANK_W + PRG_OFS_W;
    localparam int CHR_BANK_W = 5;
    localparam int CHR_OFS_W  = 12;
    localparam int CHR_AW     = CHR_BANK_W + CHR_OFS_W;
    localparam int RAM_BANK_W = 2;
    localparam int RAM_OFS_W  = 13;
    localparam int RAM_AW     = RAM_BANK_W + RAM_OFS_W;

    typedef enum logic [1:0] {
        MIR_ONE_A = 2'd0,
        MIR_ONE_B = 2'd1,
        MIR_VERT  = 2'd2,
        MIR_HORZ  = 2'd3
    } mirror_e;

    typedef enum logic [1:0] {
        RAM_8K        = 2'd0,
        RAM_16K_SPLIT = 2'd1,
        RAM_16K_FLAT  = 2'd2,
        RAM_32K       = 2'd3
    } ram_cfg_e;

    typedef struct packed {
        logic              prg_ce;
        logic [PRG_AW-1:0] prg_addr;
        logic              ram_ce;
        logic              ram_batt;
        logic [RAM_AW-1:0] ram_addr;
        logic              chr_ce;
        logic [CHR_AW-1:0] chr_addr;
        logic              nt_ce;
        logic              nt_a10;
    } xlat_out_t;

endpackage

// File: rtl/cart_bank_prg.sv
module cart_bank_prg #(
    parameter int BANK_W = 5
) (
    input  logic              fixed_map,
    input  logic              wide_mode,
    input  logic              low_slot_swap,
    input  logic [BANK_W-2:0] sel,
    input  logic              hi_bit,
    input  logic              a14,
    output logic [BANK_W-1:0] bank
);
    localparam int LO_W = BANK_W - 1;

    logic [LO_W-1:0] lo_d;
    logic            hi_d;

    always_comb begin
        hi_d = hi_bit;
        if (fixed_map) begin
            hi_d = 1'b0;
            lo_d = {{(LO_W-1){1'b0}}, a14};
        end else if (wide_mode) begin
            lo_d = {sel[LO_W-1:1], a14};
        end else if (low_slot_swap) begin
            lo_d = a14 ? {LO_W{1'b1}} : sel;
        end else begin
            lo_d = a14 ? sel : {LO_W{1'b0}};
        end
        bank = {hi_d, lo_d};
    end
endmodule

// File: rtl/cart_bank_chr.sv
module cart_bank_chr #(
    parameter int BANK_W = 5
) (
    input  logic              four_k,
    input  logic [BANK_W-1:0] lo_reg,
    input  logic [BANK_W-1:0] hi_reg,
    input  logic              a12,
    output logic [BANK_W-1:0] bank
);
    always_comb begin
        if (four_k) begin
            bank = a12 ? hi_reg : lo_reg;
        end else begin
            bank = {lo_reg[BANK_W-1:1], a12};
        end
    end
endmodule

// File: rtl/cart_bank_ram.sv
module cart_bank_ram
    import cart_bank_xlat_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input  ram_cfg_e          layout,
    input  logic [BANK_W-1:0] sel,
    input  logic              battery,
    output logic [BANK_W-1:0] bank,
    output logic              batt
);
    always_comb begin
        bank = '0;
        batt = battery;
        unique case (layout)
            RAM_32K: begin
                bank = sel;
            end
            RAM_16K_SPLIT: begin
                bank[0] = sel[1];
                batt    = ~sel[1];
            end
            RAM_16K_FLAT: begin
                bank[0] = sel[0];
            end
            default: begin
                bank = '0;
            end
        endcase
    end
endmodule

// File: rtl/cart_bank_nt.sv
module cart_bank_nt
    import cart_bank_xlat_pkg::*;
(
    input  mirror_e mode,
    input  logic    a10,
    input  logic    a11,
    output logic    line
);
    always_comb begin
        unique case (mode)
            MIR_ONE_A: line = 1'b0;
            MIR_ONE_B: line = 1'b1;
            MIR_VERT:  line = a10;
            default:   line = a11;
        endcase
    end
endmodule

// File: rtl/cart_bank_xlat.sv
module cart_bank_xlat
    import cart_bank_xlat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_W-1:0]  ctl_mode,
    input  logic [REG_W-1:0]  ctl_chr_lo,
    input  logic [REG_W-1:0]  ctl_chr_hi,
    input  logic [REG_W-1:0]  ctl_prg,
    input  logic              chr_hi_last,
    input  logic              cfg_prg_512k,
    input  logic              cfg_fixed32,
    input  logic              cfg_ram_force,
    input  logic              cfg_battery,
    input  logic [1:0]        cfg_ram_size,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [PPU_AW-1:0] ppu_addr,
    output logic              prg_ce,
    output logic [PRG_AW-1:0] prg_addr,
    output logic              ram_ce,
    output logic              ram_batt,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              chr_ce,
    output logic [CHR_AW-1:0] chr_addr,
    output logic              nt_ce,
    output logic              nt_a10
);
    // Bit positions inside the control registers (decoded by this block).
    localparam int MB_SLOT   = 2;
    localparam int MB_PSIZE  = 3;
    localparam int MB_CSIZE  = 4;
    localparam int PB_RAMOFF = 4;
    localparam int XB_HIGH   = REG_W - 1;

    xlat_out_t out_d, out_q;

    logic                  use_hi_reg;
    logic                  borrow_hi;
    logic [RAM_BANK_W-1:0] borrow_ram;
    logic [PRG_BANK_W-1:0] prg_bank;
    logic [CHR_BANK_W-1:0] chr_bank;
    logic [RAM_BANK_W-1:0] ram_bank;
    logic                  ram_batt_sel;
    logic                  nt_line;
    logic                  ram_window;

    // Borrowed register: upper character register only if it was last
    // written and the character space is split into 4 KB halves.
    always_comb begin
        use_hi_reg = chr_hi_last & ctl_mode[MB_CSIZE];
        borrow_hi  = use_hi_reg ? ctl_chr_hi[XB_HIGH] : ctl_chr_lo[XB_HIGH];
        borrow_ram = use_hi_reg ? ctl_chr_hi[3:2] : ctl_chr_lo[3:2];
    end

    cart_bank_prg #(.BANK_W(PRG_BANK_W)) u_prg (
        .fixed_map     (cfg_fixed32),
        .wide_mode     (~ctl_mode[MB_PSIZE]),
        .low_slot_swap (ctl_mode[MB_SLOT]),
        .sel           (ctl_prg[PRG_BANK_W-2:0]),
        .hi_bit        (cfg_prg_512k & borrow_hi),
        .a14           (cpu_addr[PRG_OFS_W]),
        .bank          (prg_bank)
    );

    cart_bank_chr #(.BANK_W(CHR_BANK_W)) u_chr (
        .four_k (ctl_mode[MB_CSIZE]),
        .lo_reg (ctl_chr_lo),
        .hi_reg (ctl_chr_hi),
        .a12    (ppu_addr[CHR_OFS_W]),
        .bank   (chr_bank)
    );

    cart_bank_ram #(.BANK_W(RAM_BANK_W)) u_ram (
        .layout  (ram_cfg_e'(cfg_ram_size)),
        .sel     (borrow_ram),
        .battery (cfg_battery),
        .bank    (ram_bank),
        .batt    (ram_batt_sel)
    );

    cart_bank_nt u_nt (
        .mode (mirror_e'(ctl_mode[1:0])),
        .a10  (ppu_addr[10]),
        .a11  (ppu_addr[11]),
        .line (nt_line)
    );

    always_comb begin
        ram_window = (cpu_addr[CPU_AW-1:RAM_OFS_W] == 3'b011);

        out_d          = '0;
        out_d.prg_ce   = cpu_addr[CPU_AW-1];
        out_d.prg_addr = {prg_bank, cpu_addr[PRG_OFS_W-1:0]};
        out_d.ram_ce   = ram_window & (~ctl_prg[PB_RAMOFF] | cfg_ram_force);
        out_d.ram_batt = ram_batt_sel;
        out_d.ram_addr = {ram_bank, cpu_addr[RAM_OFS_W-1:0]};
        out_d.chr_ce   = ~ppu_addr[PPU_AW-1];
        out_d.chr_addr = {chr_bank, ppu_addr[CHR_OFS_W-1:0]};
        out_d.nt_ce    = ppu_addr[PPU_AW-1];
        out_d.nt_a10   = nt_line;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign prg_ce   = out_q.prg_ce;
    assign prg_addr = out_q.prg_addr;
    assign ram_ce   = out_q.ram_ce;
    assign ram_batt = out_q.ram_batt;
    assign ram_addr = out_q.ram_addr;
    assign chr_ce   = out_q.chr_ce;
    assign chr_addr = out_q.chr_addr;
    assign nt_ce    = out_q.nt_ce;
    assign nt_a10   = out_q.nt_a10;
endmodule

// File: rtl/cart_bank_xlat_chk.sv
module cart_bank_xlat_chk
    import cart_bank_xlat_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [REG_W-1:0]  ctl_mode,
    input logic [REG_W-1:0]  ctl_prg,
    input logic              cfg_prg_512k,
    input logic              cfg_fixed32,
    input logic              cfg_ram_force,
    input logic [CPU_AW-1:0] cpu_addr,
    input logic [PPU_AW-1:0] ppu_addr,
    input logic              prg_ce,
    input logic [PRG_AW-1:0] prg_addr,
    input logic              ram_ce,
    input logic              chr_ce,
    input logic [CHR_AW-1:0] chr_addr,
    input logic              nt_ce,
    input logic              nt_a10
);
    AST_SINGLE_SCREEN_LOW: assert property (@(posedge clk) disable iff (rst)
        (ctl_mode[1:0] == 2'd0 && ppu_addr[13]) |=> (nt_ce && !nt_a10)); // R1

    AST_PRG_WIDE_OFFSET: assert property (@(posedge clk) disable iff (rst)
        (!cfg_fixed32 && !ctl_mode[3] && cpu_addr[15]) |=>
            (prg_addr[14:0] == $past(cpu_addr[14:0]))); // R2

    AST_CHR_WIDE_OFFSET: assert property (@(posedge clk) disable iff (rst)
        (!ctl_mode[4] && !ppu_addr[13]) |=>
            (chr_ce && chr_addr[12:0] == $past(ppu_addr[12:0]))); // R4

    AST_RAM_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (ctl_prg[4] && !cfg_ram_force) |=> !ram_ce); // R5

    AST_CE_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(prg_ce && ram_ce) && !(chr_ce && nt_ce)); // R5

    AST_SMALL_ROM_HIGH: assert property (@(posedge clk) disable iff (rst)
        (!cfg_prg_512k && cpu_addr[15]) |=> !prg_addr[18]); // R6

    AST_FIXED_MAP: assert property (@(posedge clk) disable iff (rst)
        (cfg_fixed32 && cpu_addr[15]) |=>
            (prg_ce && prg_addr == {4'b0000, $past(cpu_addr[14:0])})); // R8
endmodule

bind cart_bank_xlat cart_bank_xlat_chk chk (
    .clk           (clk),
    .rst           (rst),
    .ctl_mode      (ctl_mode),
    .ctl_prg       (ctl_prg),
    .cfg_prg_512k  (cfg_prg_512k),
    .cfg_fixed32   (cfg_fixed32),
    .cfg_ram_force (cfg_ram_force),
    .cpu_addr      (cpu_addr),
    .ppu_addr      (ppu_addr),
    .prg_ce        (prg_ce),
    .prg_addr      (prg_addr),
    .ram_ce        (ram_ce),
    .chr_ce        (chr_ce),
    .chr_addr      (chr_addr),
    .nt_ce         (nt_ce),
    .nt_a10        (nt_a10)
);

// File: tb/cart_bank_xlat_test.sv
`timescale 1ns/1ps
module cart_bank_xlat_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  ctl_mode, ctl_chr_lo, ctl_chr_hi, ctl_prg;
    logic        chr_hi_last, cfg_prg_512k, cfg_fixed32, cfg_ram_force, cfg_battery;
    logic [1:0]  cfg_ram_size;
    logic [15:0] cpu_addr;
    logic [13:0] ppu_addr;
    logic        prg_ce, ram_ce, ram_batt, chr_ce, nt_ce, nt_a10;
    logic [18:0] prg_addr;
    logic [14:0] ram_addr;
    logic [16:0] chr_addr;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    cart_bank_xlat uut (
        .clk(clk), .rst(rst),
        .ctl_mode(ctl_mode), .ctl_chr_lo(ctl_chr_lo), .ctl_chr_hi(ctl_chr_hi), .ctl_prg(ctl_prg),
        .chr_hi_last(chr_hi_last), .cfg_prg_512k(cfg_prg_512k), .cfg_fixed32(cfg_fixed32),
        .cfg_ram_force(cfg_ram_force), .cfg_battery(cfg_battery), .cfg_ram_size(cfg_ram_size),
        .cpu_addr(cpu_addr), .ppu_addr(ppu_addr),
        .prg_ce(prg_ce), .prg_addr(prg_addr), .ram_ce(ram_ce), .ram_batt(ram_batt),
        .ram_addr(ram_addr), .chr_ce(chr_ce), .chr_addr(chr_addr), .nt_ce(nt_ce), .nt_a10(nt_a10)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic defaults();
        ctl_mode = 5'h00; ctl_chr_lo = 5'h00; ctl_chr_hi = 5'h00; ctl_prg = 5'h00;
        chr_hi_last = 1'b0; cfg_prg_512k = 1'b0; cfg_fixed32 = 1'b0;
        cfg_ram_force = 1'b0; cfg_battery = 1'b0; cfg_ram_size = 2'd0;
        cpu_addr = 16'h0000; ppu_addr = 14'h0000;
    endtask

    // Inputs change at a falling edge; the next rising edge registers them;
    // the following falling edge is where outputs are sampled.
    task automatic settle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        cpu_addr = 16'hC123; ppu_addr = 14'h2C00;
        settle();
        check("R10 reset prg_ce", {31'd0, prg_ce}, 32'd0);
        check("R10 reset prg_addr", {13'd0, prg_addr}, 32'd0);
        check("R10 reset nt_ce", {31'd0, nt_ce}, 32'd0);
        check("R10 reset chr_addr", {15'd0, chr_addr}, 32'd0);
        rst = 1'b0;
        defaults();
        settle();
    endtask

    task automatic t_mirror();
        logic [13:0] pa [4] = '{14'h2400, 14'h2800, 14'h2400, 14'h2800};
        logic        ex [4][2];
        ex = '{'{1'b0, 1'b0}, '{1'b1, 1'b1}, '{1'b1, 1'b0}, '{1'b0, 1'b1}};
        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 2; k++) begin
                ctl_mode = {3'b000, m[1:0]};
                ppu_addr = (k == 0) ? 14'h2400 : 14'h2800;
                settle();
                check("R1 nt_a10", {31'd0, nt_a10}, {31'd0, ex[m][k]});
                check("R1 nt_ce", {30'd0, nt_ce, chr_ce}, 32'd2);
            end
        end
        if (pa[0] != 14'h2400) check("R1 table", 32'd0, 32'd1);
    endtask

    task automatic t_prg32();
        ctl_mode = 5'h00; ctl_prg = 5'h07;
        cpu_addr = 16'h8123; settle();
        check("R2 R9 32K low half", {13'd0, prg_addr}, 32'h18123);
        check("R5 prg_ce", {31'd0, prg_ce}, 32'd1);
        cpu_addr = 16'hC123; settle();
        check("R2 R9 32K high half", {13'd0, prg_addr}, 32'h1C123);
    endtask

    task automatic t_latency();
        // previous state: 32K mode, cpu 0xC123 -> 0x1C123
        @(negedge clk);
        cpu_addr = 16'h8123;
        #1;
        check("R10 output held before edge", {13'd0, prg_addr}, 32'h1C123);
        @(negedge clk);
        check("R10 output after one edge", {13'd0, prg_addr}, 32'h18123);
    endtask

    task automatic t_prg16();
        ctl_mode = 5'h0C; ctl_prg = 5'h05;
        cpu_addr = 16'h8010; settle();
        check("R3 swap low, low half", {13'd0, prg_addr}, 32'h14010);
        cpu_addr = 16'hC010; settle();
        check("R3 swap low, last bank", {13'd0, prg_addr}, 32'h3C010);
        ctl_mode = 5'h08;
        cpu_addr = 16'h8010; settle();
        check("R3 swap high, first bank", {13'd0, prg_addr}, 32'h00010);
        cpu_addr = 16'hC010; settle();
        check("R3 swap high, high half", {13'd0, prg_addr}, 32'h14010);
    endtask

    task automatic t_chr();
        ctl_mode = 5'h10; ctl_chr_lo = 5'h03; ctl_chr_hi = 5'h1A;
        ppu_addr = 14'h0456; settle();
        check("R4 R9 4K low", {15'd0, chr_addr}, 32'h03456);
        check("R4 chr_ce", {30'd0, chr_ce, nt_ce}, 32'd2);
        ppu_addr = 14'h1456; settle();
        check("R4 R9 4K high", {15'd0, chr_addr}, 32'h1A456);
        ctl_mode = 5'h00;
        ppu_addr = 14'h0456; settle();
        check("R4 8K even", {15'd0, chr_addr}, 32'h02456);
        ppu_addr = 14'h1456; settle();
        check("R4 8K odd", {15'd0, chr_addr}, 32'h03456);
    endtask

    task automatic t_ram_enable();
        defaults();
        cpu_addr = 16'h6100; ctl_prg = 5'h10; settle();
        check("R5 ram disabled", {31'd0, ram_ce}, 32'd0);
        cfg_ram_force = 1'b1; settle();
        check("R5 ram forced on", {31'd0, ram_ce}, 32'd1);
        check("R9 ram_addr 8K", {17'd0, ram_addr}, 32'h0100);
        cfg_ram_force = 1'b0; ctl_prg = 5'h00; settle();
        check("R5 ram enabled", {31'd0, ram_ce}, 32'd1);
        check("R5 prg_ce low in ram window", {31'd0, prg_ce}, 32'd0);
        cpu_addr = 16'h5FFF; settle();
        check("R5 below window", {31'd0, ram_ce}, 32'd0);
        cpu_addr = 16'h8000; settle();
        check("R5 above window", {30'd0, ram_ce, prg_ce}, 32'd1);
    endtask

    task automatic t_big_prg();
        defaults();
        cfg_prg_512k = 1'b1; ctl_mode = 5'h0C; ctl_chr_lo = 5'h10; ctl_prg = 5'h02;
        cpu_addr = 16'h8000; settle();
        check("R6 high bit low slot", {13'd0, prg_addr}, 32'h48000);
        cpu_addr = 16'hC000; settle();
        check("R6 high bit last bank", {13'd0, prg_addr}, 32'h7C000);
        // 8K character mode: upper register never borrowed
        ctl_chr_lo = 5'h00; ctl_chr_hi = 5'h10; chr_hi_last = 1'b1;
        cpu_addr = 16'h8000; settle();
        check("R6 8K mode uses lower reg", {13'd0, prg_addr}, 32'h08000);
        ctl_mode = 5'h1C; settle();
        check("R6 4K mode upper last", {13'd0, prg_addr}, 32'h48000);
        chr_hi_last = 1'b0; settle();
        check("R6 4K mode lower last", {13'd0, prg_addr}, 32'h08000);
        ctl_mode = 5'h10; chr_hi_last = 1'b1; cpu_addr = 16'hC000; settle();
        check("R6 32K mode high bit", {13'd0, prg_addr}, 32'h4C000);
        cfg_prg_512k = 1'b0; settle();
        check("R6 small ROM ignores bit", {13'd0, prg_addr}, 32'h0C000);
    endtask

    task automatic t_ram_bank();
        defaults();
        cpu_addr = 16'h6ABC; cfg_battery = 1'b1;
        cfg_ram_size = 2'd3; ctl_chr_lo = 5'h0C; settle();
        check("R7 32K bank 3", {17'd0, ram_addr}, 32'h6ABC);
        ctl_chr_lo = 5'h04; settle();
        check("R7 32K bank 1", {17'd0, ram_addr}, 32'h2ABC);
        check("R7 32K batt strap", {31'd0, ram_batt}, 32'd1);
        cfg_ram_size = 2'd1; ctl_chr_lo = 5'h08; settle();
        check("R7 split work half", {16'd0, ram_batt, ram_addr}, 32'h2ABC);
        ctl_chr_lo = 5'h04; settle();
        check("R7 split battery half", {16'd0, ram_batt, ram_addr}, 32'h8ABC);
        cfg_ram_size = 2'd2; settle();
        check("R7 flat 16K bank", {17'd0, ram_addr}, 32'h2ABC);
        cfg_ram_size = 2'd0; ctl_chr_lo = 5'h0C; cfg_battery = 1'b0; settle();
        check("R7 8K ignores bits", {16'd0, ram_batt, ram_addr}, 32'h0ABC);
        // borrowed from upper register in 4K mode
        cfg_ram_size = 2'd3; ctl_mode = 5'h10; ctl_chr_lo = 5'h00;
        ctl_chr_hi = 5'h08; chr_hi_last = 1'b1; settle();
        check("R7 upper reg borrowed", {17'd0, ram_addr}, 32'h4ABC);
    endtask

    task automatic t_fixed();
        defaults();
        cfg_fixed32 = 1'b1; cfg_prg_512k = 1'b1; ctl_mode = 5'h0C;
        ctl_prg = 5'h05; ctl_chr_lo = 5'h10;
        cpu_addr = 16'h8010; settle();
        check("R8 fixed low", {13'd0, prg_addr}, 32'h00010);
        cpu_addr = 16'hC010; settle();
        check("R8 fixed high", {13'd0, prg_addr}, 32'h04010);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        defaults();
        repeat (3) @(negedge clk);
        t_reset();
        t_mirror();
        t_prg32();
        t_latency();
        t_prg16();
        t_chr();
        t_ram_enable();
        t_big_prg();
        t_ram_bank();
        t_fixed();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule